// File: doc/BRIEF.md
# Byte-Parity Bus Transceiver with Latch/Register Storage

This block joins two 16-bit data ports, A and B. Each port carries two parity bits, one for each byte. Each direction, A-to-B and B-to-A, has its own storage word. A latch-enable input and a capture strobe make that storage run in one of three modes. It can be transparent, it can hold its value, or it can load on the rising edge of the system clock. In the A-to-B direction a mode input chooses one of two behaviours. In generate mode, parity is derived freshly from the stored data. In check mode, the incoming parity is carried along with the data and compared. The B-to-A direction always checks. One shared input chooses odd or even parity sense for both directions.

Each direction reports a parity mismatch in either of its bytes on a single active-low flag. The flag is modelled the way an open-drain output behaves: a pull-down enable plus a level that is always low, so several flags can share one wire. The flag can only pull down while its direction's output enable is on. The data and parity outputs are also presented with a per-direction drive enable, which stands in for a tri-state bus.

Top module: `bytepar_xcvr`

## Requirements
- R1: While a direction's latch enable is 1, its output data and carried parity equal that direction's current inputs in the same cycle.
- R2: While latch enable is 0, a rising clock edge with the capture strobe at 1 loads the input word and parity, and that word appears on the outputs after the edge.
- R3: While latch enable is 0 and the strobe is 0, changes on a direction's inputs have no effect on its outputs.
- R4: When latch enable falls, the outputs keep the word that was present at the last rising edge while latch enable was 1.
- R5: The parity bit for byte k (data bits 8k+7 down to 8k, with k=0 the low byte) is the XOR of those 8 bits, inverted when the odd-sense input is 1.
- R6: In A-to-B check mode (generate select 0), the B parity output carries the stored A parity, and the A-to-B flag pulls down when either stored parity bit differs from its computed value.
- R7: In A-to-B generate mode (generate select 1), the B parity output equals the parity computed from the stored A data, and the A-to-B flag never pulls down.
- R8: The B-to-A direction always checks: the A parity output carries the stored B parity, and its flag pulls down on a mismatch in either byte.
- R9: A direction's flag pull-down enable is 0 whenever that direction's output enable is 0.
- R10: Each direction's data drive enable follows its output enable, and both flag levels are constant 0.
- R11: The controls and inputs of one direction have no effect on the stored word or outputs of the other direction.
- R12: Reset clears both stored words and their parity to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; captures happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | Parity sense for both directions: 1 odd, 0 even |
| ab_gen | input | 1 | A-to-B mode: 1 generate, 0 check |
| ab_le | input | 1 | A-to-B latch enable (1 transparent) |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_oe | input | 1 | A-to-B output enable |
| a_data_in | input | 16 | Data arriving on port A |
| a_par_in | input | 2 | Byte parity arriving on port A |
| b_data_out | output | 16 | Data driven onto port B |
| b_par_out | output | 2 | Byte parity driven onto port B |
| b_out_en | output | 1 | Drive enable for port B data and parity |
| ab_err_drv | output | 1 | A-to-B flag pull-down enable |
| ab_err_lvl | output | 1 | A-to-B flag level, always 0 |
| ba_le | input | 1 | B-to-A latch enable (1 transparent) |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_oe | input | 1 | B-to-A output enable |
| b_data_in | input | 16 | Data arriving on port B |
| b_par_in | input | 2 | Byte parity arriving on port B |
| a_data_out | output | 16 | Data driven onto port A |
| a_par_out | output | 2 | Byte parity driven onto port A |
| a_out_en | output | 1 | Drive enable for port A data and parity |
| ba_err_drv | output | 1 | B-to-A flag pull-down enable |
| ba_err_lvl | output | 1 | B-to-A flag level, always 0 |

## Verification
Two functions can meet in one cycle: a capture of a new word and the parity check on the word that is stored. When the strobe loads a word whose parity is wrong, the flag has to change on the same edge as the data. It must not lag one cycle behind on the old word. The bench sweeps odd/even sense, generate/check mode, output enable and every parity combination over computed data patterns. It captures a deliberately inverted word with inverted parity and compares the data, parity and flag right after that edge against values it works out arithmetically. The same sweep lets the inputs change while the direction holds, and it exercises the opposite direction, to confirm that nothing leaks.

// File: rtl/bytepar_xcvr_pkg.sv
package bytepar_xcvr_pkg;

    // Parity sense selected by the shared odd/even input.
    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_t;

    // Role of one direction's parity logic.
    typedef enum logic {
        ROLE_CHECK = 1'b0,
        ROLE_GEN   = 1'b1
    } par_role_t;

endpackage

// File: rtl/xcvr_byte_parity.sv
module xcvr_byte_parity #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    output logic [NB-1:0]     par
);
    // One XOR tree per byte; the sense bit flips even into odd.
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign par[k] = (^data[k*BYTE_W +: BYTE_W]) ^ odd;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import bytepar_xcvr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int BYTE_W  = 8,
    parameter bit HAS_GEN = 1'b0,
    localparam int NB     = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic              stb,
    input  logic              oe,
    input  logic              gen_mode,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [NB-1:0]     pin,
    output logic [DATA_W-1:0] dout,
    output logic [NB-1:0]     pout,
    output logic              out_en,
    output logic              err_drv
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NB-1:0]     par;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic [DATA_W-1:0] view_data;
    logic [NB-1:0]     view_par;
    logic [NB-1:0]     calc_par;
    logic [NB-1:0]     byte_bad;
    par_role_t         role;

    // Next-state: the word follows the inputs while transparent or strobed.
    always_comb begin
        st_d = st_q;
        if (le || stb) begin
            st_d.data = din;
            st_d.par  = pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Word seen at the output side of the storage element.
    assign view_data = le ? din : st_q.data;
    assign view_par  = le ? pin : st_q.par;

    xcvr_byte_parity #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_calc (
        .data (view_data),
        .odd  (odd_sel),
        .par  (calc_par)
    );

    if (HAS_GEN) begin : g_sel
        assign role = par_role_t'(gen_mode);
    end else begin : g_chk
        // Check-only direction: the select input is not consulted.
        logic unused_gen;
        assign unused_gen = gen_mode;
        assign role       = ROLE_CHECK;
    end

    assign byte_bad = view_par ^ calc_par;
    assign dout     = view_data;
    assign pout     = (role == ROLE_GEN) ? calc_par : view_par;
    assign out_en   = oe;
    assign err_drv  = oe && (role == ROLE_CHECK) && (|byte_bad);
endmodule

// File: rtl/bytepar_xcvr.sv
module bytepar_xcvr #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_sel,
    input  logic              ab_gen,
    input  logic              ab_le,
    input  logic              ab_stb,
    input  logic              ab_oe,
    input  logic [DATA_W-1:0] a_data_in,
    input  logic [NB-1:0]     a_par_in,
    output logic [DATA_W-1:0] b_data_out,
    output logic [NB-1:0]     b_par_out,
    output logic              b_out_en,
    output logic              ab_err_drv,
    output logic              ab_err_lvl,
    input  logic              ba_le,
    input  logic              ba_stb,
    input  logic              ba_oe,
    input  logic [DATA_W-1:0] b_data_in,
    input  logic [NB-1:0]     b_par_in,
    output logic [DATA_W-1:0] a_data_out,
    output logic [NB-1:0]     a_par_out,
    output logic              a_out_en,
    output logic              ba_err_drv,
    output logic              ba_err_lvl
);
    // A toward B: generate or check, chosen by ab_gen.
    xcvr_lane #(
        .DATA_W  (DATA_W),
        .BYTE_W  (BYTE_W),
        .HAS_GEN (1'b1)
    ) u_ab (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (ab_le),
        .stb      (ab_stb),
        .oe       (ab_oe),
        .gen_mode (ab_gen),
        .odd_sel  (odd_sel),
        .din      (a_data_in),
        .pin      (a_par_in),
        .dout     (b_data_out),
        .pout     (b_par_out),
        .out_en   (b_out_en),
        .err_drv  (ab_err_drv)
    );

    // B toward A: always checks.
    xcvr_lane #(
        .DATA_W  (DATA_W),
        .BYTE_W  (BYTE_W),
        .HAS_GEN (1'b0)
    ) u_ba (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (ba_le),
        .stb      (ba_stb),
        .oe       (ba_oe),
        .gen_mode (1'b0),
        .odd_sel  (odd_sel),
        .din      (b_data_in),
        .pin      (b_par_in),
        .dout     (a_data_out),
        .pout     (a_par_out),
        .out_en   (a_out_en),
        .err_drv  (ba_err_drv)
    );

    // Open-drain flags only ever pull low.
    assign ab_err_lvl = 1'b0;
    assign ba_err_lvl = 1'b0;
endmodule

// File: rtl/bytepar_xcvr_chk.sv
module bytepar_xcvr_chk #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ab_gen,
    input logic              ab_le,
    input logic              ab_stb,
    input logic              ab_oe,
    input logic [DATA_W-1:0] a_data_in,
    input logic [NB-1:0]     a_par_in,
    input logic [DATA_W-1:0] b_data_out,
    input logic [NB-1:0]     b_par_out,
    input logic              ab_err_drv,
    input logic              ba_le,
    input logic              ba_stb,
    input logic              ba_oe,
    input logic [DATA_W-1:0] b_data_in,
    input logic [DATA_W-1:0] a_data_out,
    input logic              ba_err_drv
);
    a_r9_ab_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe |-> !ab_err_drv);

    a_r9_ba_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe |-> !ba_err_drv);

    a_r7_gen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ab_gen |-> !ab_err_drv);

    a_r1_ab_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_data_out == a_data_in));

    a_r6_par_carried: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !ab_gen) |-> (b_par_out == a_par_in));

    a_r2_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_stb) |=> (ab_le || b_data_out == $past(a_data_in)));

    a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_stb) |=> (ab_le || $stable(b_data_out)));

    a_r8_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && ba_stb) |=> (ba_le || a_data_out == $past(b_data_in)));

    a_r3_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !ba_stb) |=> (ba_le || $stable(a_data_out)));
endmodule

bind bytepar_xcvr bytepar_xcvr_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ab_gen     (ab_gen),
    .ab_le      (ab_le),
    .ab_stb     (ab_stb),
    .ab_oe      (ab_oe),
    .a_data_in  (a_data_in),
    .a_par_in   (a_par_in),
    .b_data_out (b_data_out),
    .b_par_out  (b_par_out),
    .ab_err_drv (ab_err_drv),
    .ba_le      (ba_le),
    .ba_stb     (ba_stb),
    .ba_oe      (ba_oe),
    .b_data_in  (b_data_in),
    .a_data_out (a_data_out),
    .ba_err_drv (ba_err_drv)
);

// File: tb/bytepar_xcvr_bench.sv
`timescale 1ns/1ps
module bytepar_xcvr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        odd_sel = 1'b0, ab_gen = 1'b0;
    logic        ab_le = 1'b0, ab_stb = 1'b0, ab_oe = 1'b0;
    logic [15:0] a_data_in = '0;
    logic [1:0]  a_par_in = '0;
    logic [15:0] b_data_out;
    logic [1:0]  b_par_out;
    logic        b_out_en, ab_err_drv, ab_err_lvl;
    logic        ba_le = 1'b0, ba_stb = 1'b0, ba_oe = 1'b0;
    logic [15:0] b_data_in = '0;
    logic [1:0]  b_par_in = '0;
    logic [15:0] a_data_out;
    logic [1:0]  a_par_out;
    logic        a_out_en, ba_err_drv, ba_err_lvl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bytepar_xcvr u_bytepar_xcvr (.*);

    function automatic logic [1:0] pcalc(input logic [15:0] d, input logic o);
        return {(^d[15:8]) ^ o, (^d[7:0]) ^ o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_neg();
        @(negedge clk);
    endtask

    // Check the A-to-B outputs against a stored word d with parity p.
    task automatic ab_expect(input string req, input logic [15:0] d, input logic [1:0] p);
        logic [1:0] cp;
        cp = pcalc(d, odd_sel);
        chk({req, " data"}, b_data_out, d);
        chk({req, " R5/R6/R7 par"}, b_par_out, ab_gen ? cp : p);
        chk({req, " R6/R9 flag"}, ab_err_drv, ab_oe && !ab_gen && (p != cp));
        chk({req, " R10 en"}, b_out_en, ab_oe);
    endtask

    task automatic ba_expect(input string req, input logic [15:0] d, input logic [1:0] p);
        logic [1:0] cp;
        cp = pcalc(d, odd_sel);
        chk({req, " data"}, a_data_out, d);
        chk({req, " R8 par"}, a_par_out, p);
        chk({req, " R8/R9 flag"}, ba_err_drv, ba_oe && (p != cp));
        chk({req, " R10 en"}, a_out_en, ba_oe);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] ab_mem, ba_mem;
        logic [1:0]  ab_pm, ba_pm;

        // R12: reset state with storage holding.
        odd_sel = 1'b0;
        #25;
        chk("R12 b data", b_data_out, 16'h0);
        chk("R12 a data", a_data_out, 16'h0);
        chk("R12 b par", b_par_out, 2'b00);
        chk("R12 a par", a_par_out, 2'b00);
        chk("R10 lvl", {ab_err_lvl, ba_err_lvl}, 2'b00);
        step_neg();
        rst_n = 1'b1;
        ba_mem = '0;
        ba_pm  = '0;

        // A-to-B sweep; B-to-A held idle throughout (R11).
        for (int i = 0; i < 64; i++) begin
            logic [15:0] d, d2;
            logic [1:0]  p, p2;
            d  = 16'(((i + 1) * 16'hA5C3) ^ (i << 9));
            p  = 2'(i >> 4);
            d2 = ~d;
            p2 = ~p;
            step_neg();
            odd_sel = i[0];
            ab_gen = i[1];
            ab_oe = i[2];
            ab_le = 1'b1;
            ab_stb = 1'b0;
            a_data_in = d;
            a_par_in = p;
            ba_oe = i[3];
            b_data_in = d ^ 16'h5A5A;
            b_par_in = ~p;
            #2;
            ab_expect("R1 transparent", d, p);
            step_neg();
            ab_le = 1'b0;
            a_data_in = d2;
            a_par_in = p2;
            #2;
            ab_expect("R4 le drop", d, p);
            step_neg();
            ab_stb = 1'b1;
            #2;
            ab_expect("R3 pre-edge", d, p);
            step_neg();
            ab_stb = 1'b0;
            a_data_in = d + 16'h1;
            a_par_in = p;
            #2;
            ab_expect("R2 capture", d2, p2);
            step_neg();
            #2;
            ab_expect("R3 hold", d2, p2);
            ba_expect("R11 ba idle", ba_mem, ba_pm);
            ab_mem = d2;
            ab_pm = p2;
        end

        // B-to-A sweep; A-to-B held with toggling inputs (R11).
        for (int i = 0; i < 32; i++) begin
            logic [15:0] d, d2;
            logic [1:0]  p, p2;
            d  = 16'(((i + 3) * 16'h3D17) ^ (i << 11));
            p  = 2'(i >> 3);
            d2 = ~d;
            p2 = ~p;
            step_neg();
            odd_sel = i[0];
            ab_gen = i[1];
            ab_oe = i[2];
            ba_oe = i[2];
            ab_le = 1'b0;
            ab_stb = 1'b0;
            a_data_in = ~d;
            ba_le = 1'b1;
            ba_stb = 1'b0;
            b_data_in = d;
            b_par_in = p;
            #2;
            ba_expect("R1/R8 transparent", d, p);
            step_neg();
            ba_le = 1'b0;
            b_data_in = d2;
            b_par_in = p2;
            #2;
            ba_expect("R4 ba le drop", d, p);
            step_neg();
            ba_stb = 1'b1;
            step_neg();
            ba_stb = 1'b0;
            b_data_in = d ^ 16'h00FF;
            #2;
            ba_expect("R2/R8 capture", d2, p2);
            ab_expect("R11 ab idle", ab_mem, ab_pm);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule